// File: doc/BRIEF.md
# Third-Order Split-Word Cascaded Noise-Shaping Modulator

This block sits in a digital audio output path, after interpolation. It receives 24-bit two's-complement PCM samples that have already been raised to the oversampled rate. With an oversampling ratio of 256 and a 12.288 MHz modulator clock, a new sample arrives at 48 kHz, and each sample is held for 256 clocks. Every clock the block emits a 4-bit unsigned code for a sixteen-level unit-element converter. The 20 kHz audio band must keep enough resolution for more than 23 effective bits.

The sample is first turned into offset binary. The top four bits of that word go straight to the output adder. Only the twenty-bit remainder enters the noise shaper. The shaper is a cascade of two loops. The first is a second-order error-feedback loop with a coarse quantizer. The second is a first-order accumulator that requantizes the first loop's residue. Its carry is fed back into the first loop's quantizer sum, so the first loop only ever sees the second loop's shaped error. Because of this coupling, the combined code needs no cancellation filter, and the total noise shaping is third order.

The first-loop quantizer result, the second-loop carry and the upper field are added and clipped to 0..15. Each clipped cycle is counted. A sticky flag reports any overflow of the loop accumulator.

Top module: `dsm_cascade_top`

## Requirements
- R1: While `rst` is high at a clock edge, `code_out` becomes 8, `sat_count` becomes 0 and `ovf_sticky` becomes 0. All loop state is cleared to zero.
- R2: `in_sample` is captured only on an edge where `in_valid` is high, and is held otherwise. Changes on `in_sample` while `in_valid` is low have no effect on `code_out`. A sample captured at edge k first shows in `code_out` after edge k+1.
- R3: The held sample is converted to offset binary as u = x + 2^23. The upper field is u[23:20] and the lower field is u[19:0]. When the lower field is zero and the loops are still in their reset state, `code_out` equals the upper field on every cycle.
- R4: Only the lower field is noise shaped. The shaper is a second-order error-feedback loop whose quantizer sum includes the carry of a first-order second stage. The second stage requantizes the first loop's residue, and the overall shaping is third order.
- R5: Over any 256 consecutive codes taken while the sample is constant and nothing clips, the code sum S satisfies |S*4096 - u| < 16384. This means the mean is within 4/256 LSB of u/2^20.
- R6: The sum of the upper field and the shaped correction is clipped to the range 0..15. The code never wraps around.
- R7: `sat_count` goes up by one on each cycle in which clipping occurs, and stops at its maximum value. It stays unchanged when nothing clips.
- R8: `ovf_sticky` is set if the loop accumulator ever leaves its 24-bit signed range. For any input, it never sets.
- R9: The shaped correction added to the upper field always lies in -3..+4. Without clipping, every code therefore lies in [upper-3, upper+4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 24 | Two's-complement PCM sample |
| code_out | output | 4 | Unsigned code for the sixteen-level converter |
| sat_count | output | 16 | Saturating count of clipped cycles |
| ovf_sticky | output | 1 | Sticky accumulator overflow flag |

## Verification
The bench sends a slow staircase of samples with non-zero lower fields and checks the 256-code sum of each step against u. A design that lost the second-stage coupling, doubled the wrong error tap or dropped the MSB flip would drift by whole codes and fail the bound. It checks the reset state exactly, and a zero lower field gives a flat code, so a wrong split or a wrong capture latency is seen on a specific cycle. Inputs at both extremes drive the sum past 15 and below 0. There a wrapping adder would produce codes far from the rail, and a counter that did not advance would stay at zero. An input that changes without the strobe must leave the output unchanged.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int DEF_IN_W  = 24;
  localparam int DEF_OUT_W = 4;
  localparam int DEF_CNT_W = 16;

  // Bounds of the shaped correction for the third-order cascade
  localparam int CORR_LO = -3;
  localparam int CORR_HI = 4;

  // Clip a signed level into the unsigned code range 0..maxv
  function automatic int clip_code(input int level, input int maxv);
    if (level < 0)    return 0;
    if (level > maxv) return maxv;
    return level;
  endfunction

  // True when the level lies outside 0..maxv
  function automatic logic is_clipped(input int level, input int maxv);
    return (level < 0) || (level > maxv);
  endfunction
endpackage

// File: rtl/dsm_split_hold.sv
module dsm_split_hold #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 4,
  localparam int FRAC_W = IN_W - OUT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_sample,
  output logic [OUT_W-1:0]  upper_o,
  output logic [FRAC_W-1:0] lower_o
);
  logic [IN_W-1:0] sample_q;
  logic [IN_W-1:0] offset_bin;

  always_ff @(posedge clk) begin
    if (rst)           sample_q <= '0;
    else if (in_valid) sample_q <= in_sample;
  end

  // Adding half scale to a two's-complement word flips its sign bit
  assign offset_bin = {~sample_q[IN_W-1], sample_q[IN_W-2:0]};
  assign upper_o    = offset_bin[IN_W-1:FRAC_W];
  assign lower_o    = offset_bin[FRAC_W-1:0];

  AST_HELD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(sample_q)); // R2
endmodule

// File: rtl/dsm_ef1_stage.sv
module dsm_ef1_stage #(
  parameter int FRAC_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FRAC_W-1:0] resid_i,
  output logic              carry_o,
  output logic [FRAC_W-1:0] rem_now_o,
  output logic [FRAC_W-1:0] rem_prev_o
);
  logic [FRAC_W:0]   acc_sum;
  logic [FRAC_W-1:0] rem_q;

  assign acc_sum    = {1'b0, resid_i} + {1'b0, rem_q};
  assign carry_o    = acc_sum[FRAC_W];
  assign rem_now_o  = acc_sum[FRAC_W-1:0];
  assign rem_prev_o = rem_q;

  always_ff @(posedge clk) begin
    if (rst) rem_q <= '0;
    else     rem_q <= rem_now_o;
  end
endmodule

// File: rtl/dsm_smash_core.sv
module dsm_smash_core #(
  parameter int FRAC_W = 20,
  parameter int OUT_W  = 4,
  localparam int ACC_W = FRAC_W + OUT_W,
  localparam int ERR_W = FRAC_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [FRAC_W-1:0]       lower_i,
  output logic signed [OUT_W:0]   corr_o,
  output logic                    ovf_o
);
  import dsm_pkg::*;

  logic signed [ERR_W-1:0] err_d1_q, err_d2_q, err_now;
  logic signed [ACC_W:0]   lvl_ext, d1_ext, d2_ext, acc_wide;
  logic signed [ACC_W-1:0] acc;
  logic signed [OUT_W-1:0] q1;
  logic                    q2;
  logic [FRAC_W-1:0]       rem_now, rem_prev;
  logic                    acc_ovf;
  logic                    ovf_q;

  // First loop: shaped lower field plus second-difference error feedback
  assign lvl_ext  = {{(ACC_W+1-FRAC_W){1'b0}}, lower_i};
  assign d1_ext   = {{(ACC_W+1-ERR_W){err_d1_q[ERR_W-1]}}, err_d1_q};
  assign d2_ext   = {{(ACC_W+1-ERR_W){err_d2_q[ERR_W-1]}}, err_d2_q};
  assign acc_wide = lvl_ext - (d1_ext <<< 1) + d2_ext;
  assign acc_ovf  = acc_wide[ACC_W] != acc_wide[ACC_W-1];
  assign acc      = acc_wide[ACC_W-1:0];

  // Coarse floor quantizer: integer steps above the fractional residue
  assign q1 = acc[ACC_W-1:FRAC_W];

  // Second stage requantizes the residue the first quantizer discarded
  dsm_ef1_stage #(.FRAC_W(FRAC_W)) u_stage2 (
    .clk        (clk),
    .rst        (rst),
    .resid_i    (acc[FRAC_W-1:0]),
    .carry_o    (q2),
    .rem_now_o  (rem_now),
    .rem_prev_o (rem_prev)
  );

  // Coupled loop error: first difference of the second stage's error
  assign err_now = $signed({2'b00, rem_prev}) - $signed({2'b00, rem_now});

  always_ff @(posedge clk) begin
    if (rst) begin
      err_d1_q <= '0;
      err_d2_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      err_d1_q <= err_now;
      err_d2_q <= err_d1_q;
      ovf_q    <= ovf_q | acc_ovf;
    end
  end

  assign corr_o = {q1[OUT_W-1], q1} + {{OUT_W{1'b0}}, q2};
  assign ovf_o  = ovf_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !acc_ovf); // R8
  AST_CORR_RANGE: assert property (@(posedge clk) disable iff (rst)
    (corr_o >= CORR_LO) && (corr_o <= CORR_HI)); // R9
  AST_FIRST_Q_RANGE: assert property (@(posedge clk) disable iff (rst)
    (q1 >= CORR_LO) && (q1 <= CORR_HI - 1)); // R4
endmodule

// File: rtl/dsm_recombine.sv
module dsm_recombine #(
  parameter int OUT_W = 4,
  parameter int CNT_W = 16,
  localparam int CODE_MAX = (1 << OUT_W) - 1,
  localparam int CODE_MID = 1 << (OUT_W - 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [OUT_W-1:0]      upper_i,
  input  logic signed [OUT_W:0] corr_i,
  output logic [OUT_W-1:0]      code_o,
  output logic [CNT_W-1:0]      sat_cnt_o
);
  import dsm_pkg::*;

  logic signed [OUT_W+1:0] level;
  logic                    clip_ev;
  logic                    clip_hi;
  logic [OUT_W-1:0]        code_d;
  logic [OUT_W-1:0]        code_q;
  logic [CNT_W-1:0]        cnt_q;

  assign level   = $signed({2'b00, upper_i}) + $signed({corr_i[OUT_W], corr_i});
  assign clip_ev = is_clipped(int'(level), CODE_MAX);
  assign clip_hi = int'(level) > CODE_MAX;
  assign code_d  = OUT_W'(clip_code(int'(level), CODE_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= OUT_W'(CODE_MID);
      cnt_q  <= '0;
    end else begin
      code_q <= code_d;
      if (clip_ev && (cnt_q != '1)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign code_o    = code_q;
  assign sat_cnt_o = cnt_q;

  AST_RESET_MID: assert property (@(posedge clk)
    rst |=> (code_q == OUT_W'(CODE_MID)) && (cnt_q == '0)); // R1
  AST_CLIP_HI: assert property (@(posedge clk) disable iff (rst)
    clip_hi |=> (code_q == OUT_W'(CODE_MAX))); // R6
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (clip_ev && (cnt_q != '1)) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R7
  AST_CNT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !clip_ev |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/dsm_cascade_top.sv
module dsm_cascade_top #(
  parameter int IN_W  = dsm_pkg::DEF_IN_W,
  parameter int OUT_W = dsm_pkg::DEF_OUT_W,
  parameter int CNT_W = dsm_pkg::DEF_CNT_W,
  localparam int FRAC_W = IN_W - OUT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_sample,
  output logic [OUT_W-1:0] code_out,
  output logic [CNT_W-1:0] sat_count,
  output logic             ovf_sticky
);
  logic [OUT_W-1:0]      upper_w;
  logic [FRAC_W-1:0]     lower_w;
  logic signed [OUT_W:0] corr_w;

  dsm_split_hold #(.IN_W(IN_W), .OUT_W(OUT_W)) u_split (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .upper_o   (upper_w),
    .lower_o   (lower_w)
  );

  dsm_smash_core #(.FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .lower_i (lower_w),
    .corr_o  (corr_w),
    .ovf_o   (ovf_sticky)
  );

  dsm_recombine #(.OUT_W(OUT_W), .CNT_W(CNT_W)) u_join (
    .clk       (clk),
    .rst       (rst),
    .upper_i   (upper_w),
    .corr_i    (corr_w),
    .code_o    (code_out),
    .sat_cnt_o (sat_count)
  );
endmodule

// File: tb/tb_dsm_cascade_top.sv
`timescale 1ns/1ps
module tb_dsm_cascade_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [23:0] in_sample = '0;
  logic [3:0]  code_out;
  logic [15:0] sat_count;
  logic        ovf_sticky;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct { int u; int mode; } win_t;   // mode 0 mid, 1 top clip, 2 bottom clip
  win_t exp_q[$];
  event win_go;

  always #2.5 clk = ~clk;

  dsm_cascade_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .code_out(code_out), .sat_count(sat_count), .ovf_sticky(ovf_sticky)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: strobe a sample, let it settle, then hand a 256-code window to the monitor
  task automatic drive_window(input int u, input int mode);
    win_t w;
    @(negedge clk);
    in_sample = 24'(u - (1 << 23));
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid  = 1'b0;
    repeat (4) @(negedge clk);
    w.u = u; w.mode = mode;
    exp_q.push_back(w);
    -> win_go;
    repeat (257) @(negedge clk);
  endtask

  // Monitor: accumulate 256 codes and compare against the expected level
  initial begin
    forever begin
      win_t w;
      int sum, up, cmin, cmax, sat0;
      longint d;
      @(win_go);
      w = exp_q.pop_front();
      up = w.u >> 20;
      sum = 0; cmin = 99; cmax = -1; sat0 = int'(sat_count);
      for (int i = 0; i < 256; i++) begin
        sum += int'(code_out);
        if (int'(code_out) < cmin) cmin = int'(code_out);
        if (int'(code_out) > cmax) cmax = int'(code_out);
        @(negedge clk);
      end
      if (w.mode == 0) begin
        d = longint'(sum) * 4096 - longint'(w.u);
        check(d > -16384 && d < 16384, "R5 window mean", longint'(sum) * 4096, w.u);
        check(cmin >= up - 3 && cmax <= up + 4, "R9 code spread low", cmin, up - 3);
        check(int'(sat_count) == sat0, "R7 counter quiet", sat_count, sat0);
        check(ovf_sticky == 1'b0, "R8 overflow flag", ovf_sticky, 0);
      end else if (w.mode == 1) begin
        check(cmin >= 12, "R6 top clip no wrap", cmin, 12);
        check(cmax == 15, "R6 top rail reached", cmax, 15);
        check(int'(sat_count) > sat0, "R7 counter advances top", sat_count, sat0 + 1);
        check(ovf_sticky == 1'b0, "R8 overflow flag at top", ovf_sticky, 0);
      end else begin
        check(cmax <= 4, "R6 bottom clip no wrap", cmax, 4);
        check(cmin == 0, "R6 bottom rail reached", cmin, 0);
        check(int'(sat_count) > sat0, "R7 counter advances bottom", sat_count, sat0 + 1);
        check(ovf_sticky == 1'b0, "R8 overflow flag at bottom", ovf_sticky, 0);
      end
    end
  end

  task automatic run_all();
    // R1: reset state
    repeat (3) @(negedge clk);
    check(code_out == 4'd8, "R1 reset code", code_out, 8);
    check(sat_count == 16'd0, "R1 reset counter", sat_count, 0);
    check(ovf_sticky == 1'b0, "R1 reset overflow", ovf_sticky, 0);
    rst = 1'b0;
    @(negedge clk);
    check(code_out == 4'd8, "R3 zero sample gives mid code", code_out, 8);
    // R2 latency: strobe upper=11, lower=0
    in_sample = 24'((11 << 20) - (1 << 23));
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid  = 1'b0;
    check(code_out == 4'd8, "R2 one edge after capture still old", code_out, 8);
    @(negedge clk);
    check(code_out == 4'd11, "R2 new sample after second edge", code_out, 11);
    // R3: zero lower field from reset state gives a flat code
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(code_out == 4'd11, "R3 flat code equals upper", code_out, 11);
    end
    // R2: input changes without strobe are ignored
    for (int i = 0; i < 20; i++) begin
      in_sample = 24'(i * 98765 + 12345);
      @(negedge clk);
      check(code_out == 4'd11, "R2 unstrobed change ignored", code_out, 11);
    end
    // R4/R5: slow staircase with non-zero lower fields
    for (int k = 0; k < 12; k++)
      drive_window(3 * (1 << 20) + 12345 + k * 761777, 0);
    drive_window((1 << 23) + 1, 0);
    // R6/R7: both rails
    drive_window((1 << 24) - 1, 1);
    drive_window(1 << 18, 2);
    drive_window(7 * (1 << 20) + 333333, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule